// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This unit sits between a 32-bit execution datapath and a data memory organised as 32-bit words with one write enable per byte lane. It forms the effective address by adding a base register value to a sign-extended 16-bit displacement. On the store side it turns a store request into byte-lane write enables and write data. The store data is copied across every lane, so the enables alone decide which bytes change. It also flags a store whose address is not a multiple of its size.

On the load side, the memory word comes back together with the access size, a signed/unsigned selector and the two low address bits that the requester kept. The unit picks the addressed byte or halfword and extends it to 32 bits. It returns the result from a register one cycle later. A misaligned load produces an error flag and a zero result.

Byte order is little-endian: byte lane k holds data bits [8k+7:8k] and is addressed by address bits [1:0] equal to k. Size codes are 2'b00 for byte, 2'b01 for halfword and 2'b10 for word. The code 2'b11 is handled as a word.

Top module: `lsu_align`

## Requirements
- R1: `eff_addr_o` equals `base_i` plus `offset_i` sign-extended to 32 bits, modulo 2^32.
- R2: An aligned byte store (`st_size_i`=2'b00) drives `wr_be_o` one-hot at bit `eff_addr_o[1:0]`, and drives `wr_data_o` with four copies of `st_data_i[7:0]`.
- R3: An aligned halfword store (`st_size_i`=2'b01) drives `wr_be_o`=4'b0011 when `eff_addr_o[1]`=0 and 4'b1100 when it is 1. It drives `wr_data_o` with two copies of `st_data_i[15:0]`.
- R4: An aligned word store (`st_size_i`=2'b10) drives `wr_be_o`=4'b1111 and `wr_data_o`=`st_data_i`.
- R5: A store is misaligned when it is a halfword with `eff_addr_o[0]`=1, or a word with `eff_addr_o[1:0]`≠0. A misaligned store raises `st_misalign_o` and forces `wr_be_o` to 0. A byte store is never misaligned.
- R6: With `st_en_i`=0, `wr_be_o`=0 and `st_misalign_o`=0, whatever the size and address.
- R7: A signed byte load (`ld_size_i`=2'b00, `ld_unsigned_i`=0) returns byte lane `ld_off_i` with bit 7 copied into bits [31:8].
- R8: An unsigned byte load returns byte lane `ld_off_i` with bits [31:8] at zero.
- R9: A halfword load returns `rd_data_i[15:0]` when `ld_off_i[1]`=0 and `rd_data_i[31:16]` when it is 1. The value is sign-extended when `ld_unsigned_i`=0 and zero-extended when it is 1.
- R10: A word load returns `rd_data_i` unchanged, whatever the value of `ld_unsigned_i`.
- R11: A misaligned load, judged by the same rule as in R5 applied to `ld_off_i`, sets `ld_err_o`=1 and `ld_result_o`=0 for the cycle in which `ld_valid_o`=1.
- R12: `ld_valid_o`, `ld_result_o` and `ld_err_o` are updated on the clock edge that samples `rd_valid_i`=1. The next cycle after `rd_valid_i`=0 has `ld_valid_o`=0 and `ld_err_o`=0, and `ld_result_o` keeps its value. Reset clears all three.
- R13: Size code 2'b11 behaves exactly as a word for stores, loads and the alignment check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed displacement |
| eff_addr_o | output | 32 | Effective byte address |
| st_en_i | input | 1 | Store request this cycle |
| st_size_i | input | 2 | Store size code |
| st_data_i | input | 32 | Source register value for the store |
| wr_be_o | output | 4 | Byte-lane write enables |
| wr_data_o | output | 32 | Lane-replicated write data |
| st_misalign_o | output | 1 | Store alignment error |
| rd_valid_i | input | 1 | Memory read word valid |
| rd_data_i | input | 32 | Memory read word |
| ld_size_i | input | 2 | Load size code |
| ld_unsigned_i | input | 1 | Zero-extend narrow load when 1 |
| ld_off_i | input | 2 | Low address bits of the load |
| ld_result_o | output | 32 | Extended load value (registered) |
| ld_valid_o | output | 1 | Load result valid |
| ld_err_o | output | 1 | Load alignment error |

## Verification
The hardest cases to reach are the sign boundary of a narrow load taken from an upper lane, and a misaligned store whose low address bits are produced by the adder from a negative displacement rather than by the base. To reach them, the stimulus fills memory words with a different pattern in each lane, including 0x80 and 0x8000 values in lanes 1 and 3. It also drives stores through bases and negative offsets whose sum ends in each of the four low-bit combinations. Back-to-back load beats with validity dropping in between show that the result holds.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  localparam int XLEN   = 32;
  localparam int IMM_W  = 16;
  localparam int LANES  = XLEN / 8;
  localparam int LOFF_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  function automatic logic [XLEN-1:0] ea_sum(input logic [XLEN-1:0] base,
                                             input logic [IMM_W-1:0] disp);
    return base + {{(XLEN-IMM_W){disp[IMM_W-1]}}, disp};
  endfunction

  function automatic logic is_misaligned(input acc_size_e sz,
                                         input logic [LOFF_W-1:0] a);
    case (sz)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return a[0];
      default: return |a;
    endcase
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input acc_size_e sz,
                                                 input logic [LOFF_W-1:0] a);
    logic [LANES-1:0] one_b, two_b;
    one_b = {{(LANES-1){1'b0}}, 1'b1};
    two_b = {{(LANES-2){1'b0}}, 2'b11};
    case (sz)
      SZ_BYTE: return one_b << a;
      SZ_HALF: return two_b << {a[LOFF_W-1:1], 1'b0};
      default: return {LANES{1'b1}};
    endcase
  endfunction

  function automatic logic [XLEN-1:0] pick_extend(input acc_size_e sz,
                                                  input logic uns,
                                                  input logic [LOFF_W-1:0] a,
                                                  input logic [XLEN-1:0] word);
    logic [XLEN-1:0] sh;
    case (sz)
      SZ_BYTE: begin
        sh = word >> {a, 3'b000};
        return uns ? {{(XLEN-8){1'b0}}, sh[7:0]}
                   : {{(XLEN-8){sh[7]}}, sh[7:0]};
      end
      SZ_HALF: begin
        sh = word >> {a[LOFF_W-1:1], 4'b0000};
        return uns ? {{(XLEN-16){1'b0}}, sh[15:0]}
                   : {{(XLEN-16){sh[15]}}, sh[15:0]};
      end
      default: return word;
    endcase
  endfunction
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_align_pkg::*;
(
  input  logic [XLEN-1:0]  base_i,
  input  logic [IMM_W-1:0] disp_i,
  output logic [XLEN-1:0]  ea_o
);
  assign ea_o = ea_sum(base_i, disp_i);

  always_comb begin
    if (!$isunknown({base_i, disp_i}))
      a_ea_low_r1: assert ((ea_o - base_i) == {{(XLEN-IMM_W){disp_i[IMM_W-1]}}, disp_i})
        else $error("effective address sum wrong");
  end
endmodule

// File: rtl/lsu_store_path.sv
module lsu_store_path
  import lsu_align_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_en_i,
  input  logic [1:0]        size_i,
  input  logic [LOFF_W-1:0] addr_lo_i,
  input  logic [XLEN-1:0]   data_i,
  output logic [LANES-1:0]  be_o,
  output logic [XLEN-1:0]   data_o,
  output logic              misalign_o
);
  acc_size_e        sz;
  logic             bad_align;
  logic [LANES-1:0] lane_sel;

  assign sz        = acc_size_e'(size_i);
  assign bad_align = is_misaligned(sz, addr_lo_i);
  assign lane_sel  = lane_mask(sz, addr_lo_i);

  assign misalign_o = st_en_i & bad_align;
  assign be_o       = (st_en_i && !bad_align) ? lane_sel : '0;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      case (sz)
        SZ_BYTE: data_o[g*8 +: 8] = data_i[7:0];
        SZ_HALF: data_o[g*8 +: 8] = data_i[(g%2)*8 +: 8];
        default: data_o[g*8 +: 8] = data_i[g*8 +: 8];
      endcase
    end
  end

  p_idle_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !st_en_i |-> (be_o == '0 && !misalign_o));
  p_err_blocks_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    misalign_o |-> (be_o == '0));
  p_half_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en_i && sz == SZ_HALF && !addr_lo_i[0]) |-> ($countones(be_o) == 2 && be_o[0] == be_o[1]));
  p_byte_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_en_i && sz == SZ_BYTE) |-> ($countones(be_o) == 1 && be_o[addr_lo_i]));
endmodule

// File: rtl/lsu_load_path.sv
module lsu_load_path
  import lsu_align_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid_i,
  input  logic [XLEN-1:0]   rd_data_i,
  input  logic [1:0]        size_i,
  input  logic              uns_i,
  input  logic [LOFF_W-1:0] off_i,
  output logic [XLEN-1:0]   result_o,
  output logic              valid_o,
  output logic              err_o
);
  acc_size_e       sz;
  logic            bad_align;
  logic [XLEN-1:0] extended;

  assign sz        = acc_size_e'(size_i);
  assign bad_align = is_misaligned(sz, off_i);
  assign extended  = pick_extend(sz, uns_i, off_i, rd_data_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_o <= '0;
      valid_o  <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      valid_o <= rd_valid_i;
      err_o   <= rd_valid_i & bad_align;
      if (rd_valid_i)
        result_o <= bad_align ? '0 : extended;
    end
  end

  p_valid_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_i |=> valid_o);
  p_hold_when_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_i |=> (!valid_o && $stable(result_o)));
  p_err_zero_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (valid_o && result_o == '0));
  p_unsigned_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_i && uns_i && sz == SZ_BYTE) |=> (result_o[XLEN-1:8] == '0));
endmodule

// File: rtl/lsu_align.sv
module lsu_align
  import lsu_align_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] base_i,
  input  logic [15:0] offset_i,
  output logic [31:0] eff_addr_o,
  input  logic        st_en_i,
  input  logic [1:0]  st_size_i,
  input  logic [31:0] st_data_i,
  output logic [3:0]  wr_be_o,
  output logic [31:0] wr_data_o,
  output logic        st_misalign_o,
  input  logic        rd_valid_i,
  input  logic [31:0] rd_data_i,
  input  logic [1:0]  ld_size_i,
  input  logic        ld_unsigned_i,
  input  logic [1:0]  ld_off_i,
  output logic [31:0] ld_result_o,
  output logic        ld_valid_o,
  output logic        ld_err_o
);
  logic [XLEN-1:0] ea;

  lsu_addr_gen u_agen (
    .base_i (base_i),
    .disp_i (offset_i),
    .ea_o   (ea)
  );
  assign eff_addr_o = ea;

  lsu_store_path u_st (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_en_i    (st_en_i),
    .size_i     (st_size_i),
    .addr_lo_i  (ea[LOFF_W-1:0]),
    .data_i     (st_data_i),
    .be_o       (wr_be_o),
    .data_o     (wr_data_o),
    .misalign_o (st_misalign_o)
  );

  lsu_load_path u_ld (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_valid_i (rd_valid_i),
    .rd_data_i  (rd_data_i),
    .size_i     (ld_size_i),
    .uns_i      (ld_unsigned_i),
    .off_i      (ld_off_i),
    .result_o   (ld_result_o),
    .valid_o    (ld_valid_o),
    .err_o      (ld_err_o)
  );
endmodule

// File: tb/tb_lsu_align.sv
module tb_lsu_align;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] base_i = 0;
  logic [15:0] offset_i = 0;
  logic [31:0] eff_addr_o;
  logic        st_en_i = 0;
  logic [1:0]  st_size_i = 0;
  logic [31:0] st_data_i = 0;
  logic [3:0]  wr_be_o;
  logic [31:0] wr_data_o;
  logic        st_misalign_o;
  logic        rd_valid_i = 0;
  logic [31:0] rd_data_i = 0;
  logic [1:0]  ld_size_i = 0;
  logic        ld_unsigned_i = 0;
  logic [1:0]  ld_off_i = 0;
  logic [31:0] ld_result_o;
  logic        ld_valid_o;
  logic        ld_err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  lsu_align dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_load(input logic [1:0] sz, input logic u,
                                          input logic [1:0] off, input logic [31:0] w);
    logic [7:0] b; logic [15:0] h;
    case (off)
      2'd0: b = w[7:0];
      2'd1: b = w[15:8];
      2'd2: b = w[23:16];
      default: b = w[31:24];
    endcase
    h = off[1] ? w[31:16] : w[15:0];
    if (sz == 2'b00) return u ? {24'h0, b} : {{24{b[7]}}, b};
    if (sz == 2'b01) return u ? {16'h0, h} : {{16{h[15]}}, h};
    return w;
  endfunction

  task automatic do_store(input logic [31:0] base, input logic [15:0] off,
                          input logic [1:0] sz, input logic [31:0] d,
                          input logic [3:0] exp_be, input logic [31:0] exp_d,
                          input logic exp_err, input string req);
    @(negedge clk);
    base_i = base; offset_i = off; st_size_i = sz; st_data_i = d; st_en_i = 1;
    #1;
    chk(wr_be_o == exp_be, req, {28'h0, wr_be_o}, {28'h0, exp_be});
    chk(st_misalign_o == exp_err, req, {31'h0, st_misalign_o}, {31'h0, exp_err});
    if (!exp_err) chk(wr_data_o == exp_d, req, wr_data_o, exp_d);
    st_en_i = 0;
  endtask

  task automatic do_load(input logic [1:0] sz, input logic u, input logic [1:0] off,
                         input logic [31:0] w, input logic exp_err, input string req);
    logic [31:0] exp;
    exp = exp_err ? 32'h0 : ref_load(sz, u, off, w);
    @(negedge clk);
    rd_valid_i = 1; rd_data_i = w; ld_size_i = sz; ld_unsigned_i = u; ld_off_i = off;
    @(negedge clk);
    rd_valid_i = 0; rd_data_i = 32'hDEAD_BEEF;
    chk(ld_valid_o == 1'b1, req, {31'h0, ld_valid_o}, 32'h1);
    chk(ld_err_o == exp_err, req, {31'h0, ld_err_o}, {31'h0, exp_err});
    chk(ld_result_o == exp, req, ld_result_o, exp);
  endtask

  task automatic t_reset();
    chk(ld_valid_o == 0 && ld_err_o == 0, "R12 reset", {30'h0, ld_valid_o, ld_err_o}, 32'h0);
    chk(ld_result_o == 0, "R12 reset result", ld_result_o, 32'h0);
  endtask

  task automatic t_addr();
    @(negedge clk);
    base_i = 32'h0000_1000; offset_i = 16'hFFFC; #1;
    chk(eff_addr_o == 32'h0000_0FFC, "R1 negative offset", eff_addr_o, 32'h0000_0FFC);
    base_i = 32'hFFFF_FFF0; offset_i = 16'h0020; #1;
    chk(eff_addr_o == 32'h0000_0010, "R1 wrap", eff_addr_o, 32'h0000_0010);
    base_i = 32'h1234_0000; offset_i = 16'h7FFF; #1;
    chk(eff_addr_o == 32'h1234_7FFF, "R1 max positive", eff_addr_o, 32'h1234_7FFF);
  endtask

  task automatic t_store_byte();
    for (int k = 0; k < 4; k++)
      do_store(32'h100, 16'(k), 2'b00, 32'hAABBCC5A, 4'b0001 << k, 32'h5A5A5A5A, 0, "R2 byte store");
    do_store(32'h104, 16'hFFFF, 2'b00, 32'h0000_0081, 4'b1000, 32'h81818181, 0, "R2 byte store via negative offset");
  endtask

  task automatic t_store_half();
    do_store(32'h200, 16'h0, 2'b01, 32'h1234_BEEF, 4'b0011, 32'hBEEFBEEF, 0, "R3 low half");
    do_store(32'h204, 16'hFFFE, 2'b01, 32'h1234_BEEF, 4'b1100, 32'hBEEFBEEF, 0, "R3 high half");
  endtask

  task automatic t_store_word();
    do_store(32'h300, 16'h4, 2'b10, 32'hCAFE_F00D, 4'b1111, 32'hCAFE_F00D, 0, "R4 word store");
  endtask

  task automatic t_store_misalign();
    do_store(32'h400, 16'h1, 2'b01, 32'h1111, 4'b0000, 32'h0, 1, "R5 half odd");
    do_store(32'h400, 16'h3, 2'b01, 32'h1111, 4'b0000, 32'h0, 1, "R5 half odd high");
    do_store(32'h408, 16'hFFFE, 2'b10, 32'h2222, 4'b0000, 32'h0, 1, "R5 word at 2");
    do_store(32'h401, 16'h0, 2'b10, 32'h2222, 4'b0000, 32'h0, 1, "R5 word at 1");
    do_store(32'h403, 16'h0, 2'b00, 32'h77, 4'b1000, 32'h77777777, 0, "R5 byte never misaligned");
  endtask

  task automatic t_idle();
    @(negedge clk);
    st_en_i = 0; st_size_i = 2'b10; base_i = 32'h501; offset_i = 0; #1;
    chk(wr_be_o == 0 && st_misalign_o == 0, "R6 idle misaligned word", {27'h0, st_misalign_o, wr_be_o}, 32'h0);
    st_size_i = 2'b00; #1;
    chk(wr_be_o == 0, "R6 idle byte", {28'h0, wr_be_o}, 32'h0);
  endtask

  task automatic t_load_byte();
    for (int k = 0; k < 4; k++) begin
      do_load(2'b00, 0, 2'(k), 32'h80_7F_80_01, 0, "R7 signed byte");
      do_load(2'b00, 1, 2'(k), 32'h80_7F_80_01, 0, "R8 unsigned byte");
    end
  endtask

  task automatic t_load_half();
    do_load(2'b01, 0, 2'd0, 32'h8000_7FFF, 0, "R9 signed low half");
    do_load(2'b01, 0, 2'd2, 32'h8000_7FFF, 0, "R9 signed high half");
    do_load(2'b01, 1, 2'd2, 32'h8000_7FFF, 0, "R9 unsigned high half");
    do_load(2'b01, 1, 2'd0, 32'h0000_F123, 0, "R9 unsigned low half");
  endtask

  task automatic t_load_word();
    do_load(2'b10, 0, 2'd0, 32'h8765_4321, 0, "R10 word");
    do_load(2'b10, 1, 2'd0, 32'hF000_000F, 0, "R10 word unsigned flag");
  endtask

  task automatic t_load_misalign();
    do_load(2'b01, 0, 2'd1, 32'hFFFF_FFFF, 1, "R11 half odd load");
    do_load(2'b10, 0, 2'd2, 32'hFFFF_FFFF, 1, "R11 word load at 2");
    @(negedge clk);
    chk(ld_valid_o == 0 && ld_err_o == 0, "R12 valid drops", {30'h0, ld_valid_o, ld_err_o}, 32'h0);
    chk(ld_result_o == 32'h0, "R12 result held", ld_result_o, 32'h0);
  endtask

  task automatic t_hold();
    do_load(2'b00, 1, 2'd3, 32'h5A00_0000, 0, "R12 load before idle");
    @(negedge clk);
    rd_data_i = 32'h0;
    @(negedge clk);
    chk(ld_valid_o == 0, "R12 idle valid", {31'h0, ld_valid_o}, 32'h0);
    chk(ld_result_o == 32'h5A, "R12 idle hold", ld_result_o, 32'h5A);
  endtask

  task automatic t_reserved();
    do_store(32'h600, 16'h0, 2'b11, 32'h0102_0304, 4'b1111, 32'h0102_0304, 0, "R13 rsvd store");
    do_store(32'h602, 16'h0, 2'b11, 32'h0102_0304, 4'b0000, 32'h0, 1, "R13 rsvd misaligned");
    do_load(2'b11, 0, 2'd0, 32'h8899_AABB, 0, "R13 rsvd load");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_addr();
    t_store_byte();
    t_store_half();
    t_store_word();
    t_store_misalign();
    t_idle();
    t_load_byte();
    t_load_half();
    t_load_word();
    t_load_misalign();
    t_hold();
    t_reserved();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule